// File: doc/BRIEF.md
# Dual-Processor Mailbox Register Interface

This block joins two processors, called the host and the parasite, through one-way byte mailboxes. Each side sees eight byte locations on a port of its own. The odd offsets carry data and the even offsets return flags. There are four channels in each direction. Channel 1, in the parasite-to-host direction, is a 24-entry FIFO. Every other channel holds one byte. Both ports run in one clock domain. Each access is a one-cycle strobe with a write-enable.

Every data channel has two flags that are paired across the sides. A write on one side raises the "byte pending" flag on the other side and drops its own "room" flag. The matching read reverses both. The host also owns a 6-bit control register, updated through a set-or-clear mask write. The control register enables one host interrupt and two parasite interrupt sources. Read data and both interrupt lines are registered.

Top module: `dual_cpu_mailbox`

## Requirements
- R1: After reset the control register is 0 and both interrupts are low. All flag bytes read 0x40, except host offset 4, which reads 0xC0. The host channel 3 data register holds 0x00.
- R2: A read strobe at a clock edge loads the port's read-data output at that edge. The output then holds its value until the next read on that port.
- R3: A flag byte at offset 2k (k = 0..3, channel k+1) has bit 7 set when a byte is pending for this side in channel k+1. Bit 6 is set when this side's outgoing channel k+1 has room. Bits 5:0 are zero at offsets 2, 4 and 6.
- R4: A host write to offset 0 sets the control bits that are 1 in data[5:0] when data bit 7 is 1, and clears them when bit 7 is 0. On both sides offset 0 returns the channel 1 flags in bits 7:6 and the control bits in bits 5:0. Parasite writes to offset 0 have no effect. Host writes to offsets 2, 4 and 6 have no effect.
- R5: A write to a single-byte channel stores the byte, sets the receiver's bit 7 and clears the writer's bit 6. A read while the receiver's bit 7 is set returns the byte, clears that bit 7 and sets the writer's bit 6.
- R6: A read of a single-byte channel with bit 7 clear returns the last stored byte and changes no flag.
- R7: Parasite writes to offset 1 enter a 24-byte FIFO in order. The host's channel 1 bit 7 is set while the FIFO is not empty. The parasite's channel 1 bit 6 clears while the FIFO holds 24 bytes. A write to the full FIFO is dropped.
- R8: Each host read of offset 1 pops the oldest byte, which sets the parasite's channel 1 bit 6. A host read of offset 1 on an empty FIFO returns 0x00 and changes nothing.
- R9: The host interrupt is high when control bit 0 is set and the host channel 4 bit 7 is set.
- R10: The parasite interrupt is high when control bit 1 is set and the parasite channel 1 bit 7 is set. It is also high when control bit 2 is set and the parasite channel 4 bit 7 is set.
- R11: Each interrupt output changes on the clock edge after the edge at which its inputs change.
- R12: When one side writes a channel and the other side reads the same channel in the same cycle, the write lands first. The read returns the new byte, and the flags end as after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| h_stb | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host write enable (1 write, 0 read) |
| h_addr | input | 3 | Host offset |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| p_stb | input | 1 | Parasite access strobe |
| p_we | input | 1 | Parasite write enable |
| p_addr | input | 3 | Parasite offset |
| p_wdata | input | 8 | Parasite write data |
| p_rdata | output | 8 | Parasite read data, registered |
| h_irq | output | 1 | Host interrupt, registered |
| p_irq | output | 1 | Parasite interrupt, registered |

## Verification
A wrong FIFO pointer or count shows up on the first host pop, as a byte out of order. A wrong count also makes a flag byte change one write too early or too late around the 24th entry. A flag that is out of step on either side shows on the next flag read of either port, as a bad bit 7 or bit 6. If it sits on channel 1 or 4, it also shows one cycle later on an interrupt line. A wrong mask write to the control register shows at offset 0 on both sides and on the interrupt that the affected bit enables. The reference model is compared against both read buses and both interrupts on every cycle, so a divergence is caught within one cycle of the access that exposes it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CTL_W  = 6;

  // control bit roles
  localparam int CTL_HOST_EN  = 0;
  localparam int CTL_PAR1_EN  = 1;
  localparam int CTL_PAR4_EN  = 2;
  localparam int CTL_SET_BIT  = 7;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [CTL_W-1:0]  ctl_t;

  // flag byte: pending in bit 7, room in bit 6, low field below
  function automatic byte_t flag_byte(input logic pend, input logic room, input ctl_t low);
    return {pend, room, low};
  endfunction
endpackage

// File: rtl/mbx_byte_chan.sv
module mbx_byte_chan
  import mbx_pkg::*;
#(
  parameter bit RST_PEND = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr,
  input  byte_t wdata,
  input  logic  rd,
  output byte_t rdata,
  output logic  pend,
  output logic  room
);
  byte_t data_q;

  // a same-cycle write is seen by the read
  assign rdata = wr ? wdata : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      pend   <= RST_PEND;
      room   <= 1'b1;
    end else begin
      if (wr) data_q <= wdata;
      if (rd && (pend || wr)) begin
        pend <= 1'b0;
        room <= 1'b1;
      end else if (wr) begin
        pend <= 1'b1;
        room <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_fifo_chan.sv
module mbx_fifo_chan
  import mbx_pkg::*;
#(
  parameter  int DEPTH = 24,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  byte_t            wdata,
  input  logic             pop,
  output byte_t            rdata,
  output logic             pend,
  output logic             room,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  byte_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             empty, full, push_ok, pop_ok, bypass, store;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign bypass  = push_ok && empty && pop;
  assign store   = push_ok && !bypass;
  assign rdata   = empty ? (push_ok ? wdata : '0) : mem[rd_ptr];
  assign pend    = !empty;
  assign room    = !full;
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (store) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (store)  wr_ptr <= adv(wr_ptr);
      if (pop_ok) rd_ptr <= adv(rd_ptr);
      case ({store, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dual_cpu_mailbox.sv
module dual_cpu_mailbox
  import mbx_pkg::*;
#(
  parameter  int FIFO_DEPTH = 24,
  parameter  int PRELOAD_CH = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_stb,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic              p_stb,
  input  logic              p_we,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [DATA_W-1:0] p_rdata,
  output logic              h_irq,
  output logic              p_irq
);
  logic            h_rd, h_wr, p_rd, p_wr;
  logic [CH_W-1:0] h_ch, p_ch;
  logic [NUM_CH-1:0] h2p_wr, h2p_rd, p2h_wr, p2h_rd;
  logic [NUM_CH-1:0] h2p_pend, h2p_room, p2h_pend, p2h_room;
  byte_t           h2p_q [NUM_CH];
  byte_t           p2h_q [NUM_CH];
  ctl_t            ctl_q;
  logic [CNT_W-1:0] fifo_cnt;
  byte_t           h_next, p_next;

  assign h_rd = h_stb && !h_we;
  assign h_wr = h_stb && h_we;
  assign p_rd = p_stb && !p_we;
  assign p_wr = p_stb && p_we;
  assign h_ch = h_addr[ADDR_W-1:1];
  assign p_ch = p_addr[ADDR_W-1:1];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      h2p_wr[i] = h_wr && h_addr[0] && (h_ch == CH_W'(i));
      h2p_rd[i] = p_rd && p_addr[0] && (p_ch == CH_W'(i));
      p2h_wr[i] = p_wr && p_addr[0] && (p_ch == CH_W'(i));
      p2h_rd[i] = h_rd && h_addr[0] && (h_ch == CH_W'(i));
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mbx_byte_chan #(.RST_PEND(1'b0)) u_h2p (
      .clk(clk), .rst(rst), .wr(h2p_wr[i]), .wdata(h_wdata), .rd(h2p_rd[i]),
      .rdata(h2p_q[i]), .pend(h2p_pend[i]), .room(h2p_room[i])
    );
    if (i == 0) begin : g_fifo
      mbx_fifo_chan #(.DEPTH(FIFO_DEPTH)) u_p2h (
        .clk(clk), .rst(rst), .push(p2h_wr[i]), .wdata(p_wdata), .pop(p2h_rd[i]),
        .rdata(p2h_q[i]), .pend(p2h_pend[i]), .room(p2h_room[i]), .count(fifo_cnt)
      );
    end else begin : g_byte
      mbx_byte_chan #(.RST_PEND(i == PRELOAD_CH)) u_p2h (
        .clk(clk), .rst(rst), .wr(p2h_wr[i]), .wdata(p_wdata), .rd(p2h_rd[i]),
        .rdata(p2h_q[i]), .pend(p2h_pend[i]), .room(p2h_room[i])
      );
    end
  end

  // read muxes: data offsets use forwarded channel data, flag offsets the current state
  always_comb begin
    if (h_addr[0]) h_next = p2h_q[h_ch];
    else h_next = flag_byte(p2h_pend[h_ch], h2p_room[h_ch], (h_ch == '0) ? ctl_q : '0);
    if (p_addr[0]) p_next = h2p_q[p_ch];
    else p_next = flag_byte(h2p_pend[p_ch], p2h_room[p_ch], (p_ch == '0) ? ctl_q : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
      p_rdata <= '0;
      ctl_q   <= '0;
      h_irq   <= 1'b0;
      p_irq   <= 1'b0;
    end else begin
      if (h_rd) h_rdata <= h_next;
      if (p_rd) p_rdata <= p_next;
      if (h_wr && (h_addr == '0)) begin
        if (h_wdata[CTL_SET_BIT]) ctl_q <= ctl_q | h_wdata[CTL_W-1:0];
        else                      ctl_q <= ctl_q & ~h_wdata[CTL_W-1:0];
      end
      h_irq <= ctl_q[CTL_HOST_EN] && p2h_pend[NUM_CH-1];
      p_irq <= (ctl_q[CTL_PAR1_EN] && h2p_pend[0]) ||
               (ctl_q[CTL_PAR4_EN] && h2p_pend[NUM_CH-1]);
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter  int DEPTH = 24,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             h_stb,
  input logic             h_we,
  input logic [2:0]       h_addr,
  input logic [6:0]       ctl_cmd,
  input logic             p_stb,
  input logic             p_we,
  input logic [2:0]       p_addr,
  input logic [5:0]       ctl,
  input logic [CNT_W-1:0] cnt,
  input logic             p2h_pend1,
  input logic             p2h_pend3,
  input logic             h2p_pend0,
  input logic             h2p_pend3,
  input logic             h_irq,
  input logic             p_irq
);
  logic ctl_wr;
  assign ctl_wr = h_stb && h_we && (h_addr == 3'd0);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ctl == 6'd0 && cnt == '0 && !h_irq && !p_irq));

  assert_ctl_set_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_cmd[6]) |=> ((ctl & $past(ctl_cmd[5:0])) == $past(ctl_cmd[5:0])));

  assert_ctl_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_cmd[6]) |=> ((ctl & $past(ctl_cmd[5:0])) == 6'd0));

  assert_chan_write_R5: assert property (@(posedge clk) disable iff (rst)
    (p_stb && p_we && p_addr == 3'd3 && !(h_stb && !h_we && h_addr == 3'd3)) |=> p2h_pend1);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (p_stb && p_we && p_addr == 3'd1 && cnt == CNT_W'(DEPTH) &&
     !(h_stb && !h_we && h_addr == 3'd1)) |=> (cnt == CNT_W'(DEPTH)));

  assert_host_irq_R9: assert property (@(posedge clk) disable iff (rst)
    h_irq == $past(ctl[0] && p2h_pend3));

  assert_par_irq_R10: assert property (@(posedge clk) disable iff (rst)
    p_irq == $past((ctl[1] && h2p_pend0) || (ctl[2] && h2p_pend3)));
endmodule

bind dual_cpu_mailbox mbx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .h_stb(h_stb), .h_we(h_we), .h_addr(h_addr),
  .ctl_cmd({h_wdata[7], h_wdata[5:0]}), .p_stb(p_stb), .p_we(p_we), .p_addr(p_addr),
  .ctl(ctl_q), .cnt(fifo_cnt), .p2h_pend1(p2h_pend[1]), .p2h_pend3(p2h_pend[3]),
  .h2p_pend0(h2p_pend[0]), .h2p_pend3(h2p_pend[3]), .h_irq(h_irq), .p_irq(p_irq)
);

// File: tb/dual_cpu_mailbox_bench.sv
`timescale 1ns/100ps
module dual_cpu_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       h_stb = 0, h_we = 0, p_stb = 0, p_we = 0;
  logic [2:0] h_addr = 0, p_addr = 0;
  logic [7:0] h_wdata = 0, p_wdata = 0;
  logic [7:0] h_rdata, p_rdata;
  logic       h_irq, p_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_cpu_mailbox u_dual_cpu_mailbox (
    .clk(clk), .rst(rst),
    .h_stb(h_stb), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .p_stb(p_stb), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .h_irq(h_irq), .p_irq(p_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_ctl;
  logic [7:0] m_h2p_d [4];
  bit         m_h2p_pend [4], m_h2p_room [4];
  logic [7:0] m_p2h_d [4];
  bit         m_p2h_pend [4], m_p2h_room [4];
  logic [7:0] m_q [$];
  logic [7:0] e_hr, e_pr;
  bit         e_hi, e_pi;

  function automatic bit p2h_pending(input int ch);
    return (ch == 0) ? (m_q.size() > 0) : m_p2h_pend[ch];
  endfunction
  function automatic bit p2h_has_room(input int ch);
    return (ch == 0) ? (m_q.size() < 24) : m_p2h_room[ch];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 0; m_q.delete();
      for (int i = 0; i < 4; i++) begin
        m_h2p_d[i] = 0; m_h2p_pend[i] = 0; m_h2p_room[i] = 1;
        m_p2h_d[i] = 0; m_p2h_pend[i] = (i == 2); m_p2h_room[i] = 1;
      end
      e_hr = 0; e_pr = 0; e_hi = 0; e_pi = 0;
    end else begin
      int hc, pc;
      bit nhi, npi;
      logic [7:0] hflag, pflag;
      hc = int'(h_addr) / 2;
      pc = int'(p_addr) / 2;
      nhi = m_ctl[0] && m_p2h_pend[3];
      npi = (m_ctl[1] && m_h2p_pend[0]) || (m_ctl[2] && m_h2p_pend[3]);
      hflag = {p2h_pending(hc), m_h2p_room[hc], (hc == 0) ? 6'(m_ctl) : 6'd0};
      pflag = {m_h2p_pend[pc], p2h_has_room(pc), (pc == 0) ? 6'(m_ctl) : 6'd0};
      // writes land first
      if (h_stb && h_we) begin
        if (h_addr == 0) begin
          if (h_wdata[7]) m_ctl = m_ctl | int'(h_wdata[5:0]);
          else            m_ctl = m_ctl & ~int'(h_wdata[5:0]);
        end else if (h_addr[0]) begin
          m_h2p_d[hc] = h_wdata; m_h2p_pend[hc] = 1; m_h2p_room[hc] = 0;
        end
      end
      if (p_stb && p_we && p_addr[0]) begin
        if (pc == 0) begin
          if (m_q.size() < 24) m_q.push_back(p_wdata);
        end else begin
          m_p2h_d[pc] = p_wdata; m_p2h_pend[pc] = 1; m_p2h_room[pc] = 0;
        end
      end
      if (h_stb && !h_we) begin
        if (!h_addr[0]) e_hr = hflag;
        else if (hc == 0) e_hr = (m_q.size() > 0) ? m_q.pop_front() : 8'h00;
        else begin
          e_hr = m_p2h_d[hc];
          if (m_p2h_pend[hc]) begin m_p2h_pend[hc] = 0; m_p2h_room[hc] = 1; end
        end
      end
      if (p_stb && !p_we) begin
        if (!p_addr[0]) e_pr = pflag;
        else begin
          e_pr = m_h2p_d[pc];
          if (m_h2p_pend[pc]) begin m_h2p_pend[pc] = 0; m_h2p_room[pc] = 1; end
        end
      end
      e_hi = nhi;
      e_pi = npi;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 host rdata model", h_rdata, e_hr);
      check("R2 parasite rdata model", p_rdata, e_pr);
      check("R11 host irq model", h_irq, e_hi);
      check("R11 parasite irq model", p_irq, e_pi);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit hs, input bit hw, input logic [2:0] ha, input logic [7:0] hd,
                     input bit ps, input bit pw, input logic [2:0] pa, input logic [7:0] pd);
    h_stb = hs; h_we = hw; h_addr = ha; h_wdata = hd;
    p_stb = ps; p_we = pw; p_addr = pa; p_wdata = pd;
    @(negedge clk);
    h_stb = 0; p_stb = 0; h_we = 0; p_we = 0;
  endtask
  task automatic hwr(input logic [2:0] a, input logic [7:0] d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic hrd(input logic [2:0] a); cyc(1, 0, a, 0, 0, 0, 0, 0); endtask
  task automatic pwr(input logic [2:0] a, input logic [7:0] d); cyc(0, 0, 0, 0, 1, 1, a, d); endtask
  task automatic prd(input logic [2:0] a); cyc(0, 0, 0, 0, 1, 0, a, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    check("R1 host irq", h_irq, 0);
    check("R1 parasite irq", p_irq, 0);
    hrd(0); check("R1 host off0", h_rdata, 8'h40);
    hrd(2); check("R1 host off2", h_rdata, 8'h40);
    hrd(4); check("R1 host off4 preloaded", h_rdata, 8'hC0);
    hrd(6); check("R1 host off6", h_rdata, 8'h40);
    for (int a = 0; a < 8; a += 2) begin
      prd(3'(a)); check("R1 parasite flags", p_rdata, 8'h40);
    end
    hrd(5); check("R1 host ch3 data", h_rdata, 8'h00);
    hrd(4); check("R5 host ch3 pend cleared", h_rdata, 8'h40);
    prd(4); check("R5 parasite ch3 flags", p_rdata, 8'h40);

    // control register
    hwr(0, 8'h85);
    hrd(0); check("R4 set write host view", h_rdata, 8'h45);
    prd(0); check("R4 set write parasite view", p_rdata, 8'h45);
    hwr(0, 8'h04);
    hrd(0); check("R4 clear write", h_rdata, 8'h41);
    pwr(0, 8'hBF);
    hrd(0); check("R4 parasite ctl write ignored", h_rdata, 8'h41);
    hwr(2, 8'hFF);
    hrd(2); check("R4 host even write ignored host", h_rdata, 8'h40);
    prd(2); check("R4 host even write ignored parasite", p_rdata, 8'h40);

    // host interrupt via channel 4
    pwr(7, 8'h5A);
    check("R11 host irq lags one edge", h_irq, 0);
    idle(); check("R9 host irq raised", h_irq, 1);
    hrd(6); check("R3 host ch4 flags", h_rdata, 8'hC0);
    prd(6); check("R3 parasite ch4 flags", p_rdata, 8'h00);
    hrd(7); check("R5 host ch4 data", h_rdata, 8'h5A);
    check("R11 host irq held one edge", h_irq, 1);
    idle(); check("R9 host irq cleared", h_irq, 0);
    hrd(6); check("R5 host ch4 flags after read", h_rdata, 8'h40);
    hrd(7); check("R6 stale re-read", h_rdata, 8'h5A);
    prd(6); check("R6 parasite flags unchanged", p_rdata, 8'h40);
    idle(); idle();
    check("R2 host rdata held", h_rdata, 8'h5A);

    // parasite interrupt sources
    hwr(0, 8'h86);
    hwr(1, 8'h11);
    idle(); check("R10 parasite irq ch1", p_irq, 1);
    prd(0); check("R4 parasite off0 with ctl", p_rdata, 8'hC7);
    prd(1); check("R5 parasite ch1 data", p_rdata, 8'h11);
    idle(); check("R10 parasite irq cleared", p_irq, 0);
    hwr(7, 8'h22);
    idle(); check("R10 parasite irq ch4", p_irq, 1);
    prd(7); check("R5 parasite ch4 data", p_rdata, 8'h22);
    idle(); check("R10 parasite irq ch4 cleared", p_irq, 0);
    check("R9 host irq stays low", h_irq, 0);

    // FIFO fill, overflow and drain
    hwr(0, 8'h3F);
    hrd(0); check("R4 clear all", h_rdata, 8'h40);
    for (int i = 0; i < 24; i++) pwr(1, 8'(i * 7 + 3));
    pwr(1, 8'hEE);
    prd(0); check("R7 parasite room cleared when full", p_rdata, 8'h00);
    hrd(0); check("R7 host pending", h_rdata, 8'hC0);
    hrd(1); check("R7 fifo first byte", h_rdata, 8'h03);
    prd(0); check("R8 room after pop", p_rdata, 8'h40);
    for (int i = 1; i < 24; i++) begin
      hrd(1); check("R7 fifo order", h_rdata, i * 7 + 3);
    end
    hrd(0); check("R8 host pending cleared", h_rdata, 8'h40);
    hrd(1); check("R8 empty pop returns zero", h_rdata, 8'h00);
    prd(0); check("R8 parasite flags after empty pop", p_rdata, 8'h40);

    // same-cycle write and read
    cyc(1, 1, 3, 8'h77, 1, 0, 3, 0);
    check("R12 parasite reads new byte", p_rdata, 8'h77);
    prd(2); check("R12 parasite ch2 flags", p_rdata, 8'h40);
    hrd(2); check("R12 host ch2 flags", h_rdata, 8'h40);
    cyc(1, 0, 1, 0, 1, 1, 1, 8'h99);
    check("R12 fifo bypass", h_rdata, 8'h99);
    hrd(0); check("R12 fifo empty after bypass", h_rdata, 8'h40);
    idle();
    finish_run();
  end
endmodule